// File: doc/BRIEF.md
# Platform Power-State Rail Sequencer

This block walks a platform through its off, soft-off and fully-on power states. A power-on request starts a fixed bring-up. The always-on 3.3 V rail is enabled first, and the sleep-S3 line is held low while that rail ramps. The 5 V rail follows once the 3.3 V rail reports good, and the resume reset is released once the 5 V rail reports good. The block then waits for the host to raise its sleep-suspend line, which completes entry into soft-off.

From soft-off the host's sleep-S3 line moves the block between the S3 and S0 codes. An IO-extension rail is enabled only in S0.

A shutdown request, a lost sleep-suspend line or an expired soft-off attempt all start the same ordered walk down:
- The resume reset drops first, with both rails still up.
- After a lead delay the 3.3 V rail goes off.
- After a long off delay the 5 V rail goes off.
- The block returns to the off state.

The rail power-good inputs come from elsewhere. All durations are parameters counted in clock cycles.

Top module: `pwrseq_top`

## Requirements
- R1: After reset, and in every phase other than soft-off, S3 and S0, `state_code` is 0 (off). After reset all rail enables, `s3_hold`, `io_ext_en` and `rsm_rst_n` are low. The codes are 0 off, 1 soft-off, 2 S3, 3 S0.
- R2: Bring-up order:
  - An accepted power-on request raises `en_3v3` one cycle later, with `en_5v` still low.
  - `en_5v` rises one cycle after `pg_3v3` is seen high.
  - `rsm_rst_n` rises one cycle after `pg_5v` is seen high.
- R3: `s3_hold` is high for exactly as long as the 3.3 V rail is enabled and its power-good has not yet been seen. It stays high through any number of cycles of waiting.
- R4: Once reset is released, `slp_sus_n` seen high moves the block to soft-off (code 1) one cycle later.
- R5: The soft-off attempt window starts when the block leaves the off state. A `slp_sus_n` rise seen within cycles 1 to T_SUS_CYC of that window completes the attempt. Otherwise, in cycle T_SUS_CYC+1 the attempt is abandoned through the full walk down (R8, R9), never by a direct jump to off.
- R6: In soft-off or S3, `slp_s3_n` seen high gives S0 (code 3) one cycle later. In S0, `slp_s3_n` seen low gives S3 (code 2) one cycle later.
- R7: `io_ext_en` is high exactly while the code is S0.
- R8: Walk down, first step:
  - `rsm_rst_n` goes low on the first cycle of the walk, with both enabled rails still on.
  - `en_3v3` drops after T_LEAD_CYC+1 cycles of reset lead.
- R9: Walk down, second step:
  - `en_5v` stays on for T_OFF_CYC+1 cycles after `en_3v3` drops, then goes off and the block returns to off.
  - A 5 V rail that was never enabled stays off throughout.
- R10: Shutdown priority:
  - In the off state, `shutdown_req` blocks `pwr_on_req`.
  - In any bring-up or on phase, `shutdown_req` starts the walk one cycle later.
  - During the walk, neither request changes its timing.
- R11: `slp_sus_n` seen low in soft-off, S3 or S0 starts the walk one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_on_req | input | 1 | Request to leave the off state |
| shutdown_req | input | 1 | Request to walk down to off |
| slp_sus_n | input | 1 | Host sleep-suspend, high when deasserted |
| slp_s3_n | input | 1 | Host sleep-S3, high when deasserted |
| pg_3v3 | input | 1 | Always-on 3.3 V rail good |
| pg_5v | input | 1 | 5 V rail good |
| en_3v3 | output | 1 | Always-on 3.3 V rail enable |
| en_5v | output | 1 | 5 V rail enable |
| rsm_rst_n | output | 1 | Resume reset, active low |
| s3_hold | output | 1 | Drives the sleep-S3 line low while asserted |
| io_ext_en | output | 1 | IO-extension rail enable |
| state_code | output | 2 | Power state code |

## Verification
The checker watches four ordering rules on every cycle:
- `en_5v` never rises unless the 3.3 V rail is enabled and was good the cycle before.
- The sleep-S3 override appears only during the 3.3 V ramp.
- `en_3v3` never falls unless the resume reset has already been low for two cycles.
- `en_5v` never falls before the counted off gap has elapsed.

The checker also enforces request priority in the off state and the rail and reset conditions implied by a nonzero state code.

Only the bench scenarios can show the exact lengths of the soft-off attempt, the reset lead and the off gap, and the last-cycle boundary of the attempt window. The same holds for the S3/S0 tracking under random sleep-S3 traffic and for the walk after suspend loss.

// File: rtl/pwrseq_pkg.sv
`timescale 1ns/1ps
package pwrseq_pkg;

  typedef enum logic [3:0] {
    PH_G3, PH_UP3, PH_UP5, PH_SUSW, PH_S5, PH_S3, PH_S0, PH_DNRST, PH_DN3
  } phase_e;

  typedef enum logic [1:0] {
    CODE_G3 = 2'd0, CODE_S5 = 2'd1, CODE_S3 = 2'd2, CODE_S0 = 2'd3
  } pcode_e;

  typedef struct packed {
    logic   en_3v3;
    logic   en_5v;
    logic   rsm_rst_n;
    logic   s3_hold;
    logic   io_ext_en;
    pcode_e code;
  } drive_t;

  // Width of a down-counter able to hold n.
  function automatic int cyc_w(input int unsigned n);
    int w;
    w = $clog2(n + 1);
    return (w < 1) ? 1 : w;
  endfunction

  // Pin levels for each phase; had5 marks a 5 V rail already enabled.
  function automatic drive_t decode(input phase_e p, input logic had5);
    drive_t d;
    d = '{en_3v3: 1'b0, en_5v: 1'b0, rsm_rst_n: 1'b0, s3_hold: 1'b0,
          io_ext_en: 1'b0, code: CODE_G3};
    unique case (p)
      PH_G3:    ;
      PH_UP3:   begin d.en_3v3 = 1'b1; d.s3_hold = 1'b1; end
      PH_UP5:   begin d.en_3v3 = 1'b1; d.en_5v = 1'b1; end
      PH_SUSW:  begin d.en_3v3 = 1'b1; d.en_5v = 1'b1; d.rsm_rst_n = 1'b1; end
      PH_S5:    begin d.en_3v3 = 1'b1; d.en_5v = 1'b1; d.rsm_rst_n = 1'b1;
                      d.code = CODE_S5; end
      PH_S3:    begin d.en_3v3 = 1'b1; d.en_5v = 1'b1; d.rsm_rst_n = 1'b1;
                      d.code = CODE_S3; end
      PH_S0:    begin d.en_3v3 = 1'b1; d.en_5v = 1'b1; d.rsm_rst_n = 1'b1;
                      d.io_ext_en = 1'b1; d.code = CODE_S0; end
      PH_DNRST: begin d.en_3v3 = 1'b1; d.en_5v = had5; end
      PH_DN3:   begin d.en_5v = had5; end
      default:  ;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/pwrseq_timer.sv
`timescale 1ns/1ps
module pwrseq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/pwrseq_fsm.sv
`timescale 1ns/1ps
module pwrseq_fsm
  import pwrseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pwr_on_req,
  input  logic   shutdown_req,
  input  logic   slp_sus_n,
  input  logic   slp_s3_n,
  input  logic   pg_3v3,
  input  logic   pg_5v,
  input  logic   att_done,
  input  logic   dn_done,
  output phase_e phase,
  output logic   had5,
  output logic   att_load,
  output logic   dn_load,
  output logic   dn_sel_off
);
  phase_e nxt;
  logic   walk_start;   // event: a walk down begins this cycle
  logic   on_phase;
  logic   up_phase;

  assign up_phase = (phase == PH_UP3) || (phase == PH_UP5) || (phase == PH_SUSW);
  assign on_phase = (phase == PH_S5) || (phase == PH_S3) || (phase == PH_S0);
  assign walk_start = (up_phase && (shutdown_req || att_done)) ||
                      (on_phase && (shutdown_req || !slp_sus_n));

  always_comb begin
    nxt        = phase;
    att_load   = 1'b0;
    dn_load    = 1'b0;
    dn_sel_off = 1'b0;
    if (walk_start) begin
      nxt     = PH_DNRST;
      dn_load = 1'b1;
    end else begin
      unique case (phase)
        PH_G3:    if (pwr_on_req && !shutdown_req) begin
                    nxt = PH_UP3; att_load = 1'b1;
                  end
        PH_UP3:   if (pg_3v3)    nxt = PH_UP5;
        PH_UP5:   if (pg_5v)     nxt = PH_SUSW;
        PH_SUSW:  if (slp_sus_n) nxt = PH_S5;
        PH_S5:    if (slp_s3_n)  nxt = PH_S0;
        PH_S3:    if (slp_s3_n)  nxt = PH_S0;
        PH_S0:    if (!slp_s3_n) nxt = PH_S3;
        PH_DNRST: if (dn_done) begin
                    nxt = PH_DN3; dn_load = 1'b1; dn_sel_off = 1'b1;
                  end
        PH_DN3:   if (dn_done)   nxt = PH_G3;
        default:  nxt = PH_G3;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_G3;
      had5  <= 1'b0;
    end else begin
      phase <= nxt;
      if (phase == PH_G3)       had5 <= 1'b0;
      else if (phase == PH_UP5) had5 <= 1'b1;
    end
  end
endmodule

// File: rtl/pwrseq_outdec.sv
`timescale 1ns/1ps
module pwrseq_outdec
  import pwrseq_pkg::*;
(
  input  phase_e     phase,
  input  logic       had5,
  output logic       en_3v3,
  output logic       en_5v,
  output logic       rsm_rst_n,
  output logic       s3_hold,
  output logic       io_ext_en,
  output logic [1:0] state_code
);
  drive_t d;
  assign d          = decode(phase, had5);
  assign en_3v3     = d.en_3v3;
  assign en_5v      = d.en_5v;
  assign rsm_rst_n  = d.rsm_rst_n;
  assign s3_hold    = d.s3_hold;
  assign io_ext_en  = d.io_ext_en;
  assign state_code = d.code;
endmodule

// File: rtl/pwrseq_top.sv
`timescale 1ns/1ps
module pwrseq_top
  import pwrseq_pkg::*;
#(
  parameter int unsigned T_SUS_CYC  = 12_500_000,
  parameter int unsigned T_OFF_CYC  = 3_000_000,
  parameter int unsigned T_LEAD_CYC = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_on_req,
  input  logic       shutdown_req,
  input  logic       slp_sus_n,
  input  logic       slp_s3_n,
  input  logic       pg_3v3,
  input  logic       pg_5v,
  output logic       en_3v3,
  output logic       en_5v,
  output logic       rsm_rst_n,
  output logic       s3_hold,
  output logic       io_ext_en,
  output logic [1:0] state_code
);
  localparam int ATT_W = cyc_w(T_SUS_CYC);
  localparam int DN_W  = cyc_w((T_OFF_CYC > T_LEAD_CYC) ? T_OFF_CYC : T_LEAD_CYC);
  localparam logic [ATT_W-1:0] ATT_V  = ATT_W'(T_SUS_CYC);
  localparam logic [DN_W-1:0]  OFF_V  = DN_W'(T_OFF_CYC);
  localparam logic [DN_W-1:0]  LEAD_V = DN_W'(T_LEAD_CYC);

  phase_e phase;
  logic   had5;
  logic   att_load, att_done;
  logic   dn_load, dn_done, dn_sel_off;

  pwrseq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .pwr_on_req(pwr_on_req), .shutdown_req(shutdown_req),
    .slp_sus_n(slp_sus_n), .slp_s3_n(slp_s3_n),
    .pg_3v3(pg_3v3), .pg_5v(pg_5v),
    .att_done(att_done), .dn_done(dn_done),
    .phase(phase), .had5(had5),
    .att_load(att_load), .dn_load(dn_load), .dn_sel_off(dn_sel_off)
  );

  pwrseq_timer #(.W(ATT_W)) u_att_tmr (
    .clk(clk), .rst_n(rst_n), .load(att_load), .val(ATT_V), .done(att_done)
  );

  pwrseq_timer #(.W(DN_W)) u_dn_tmr (
    .clk(clk), .rst_n(rst_n), .load(dn_load),
    .val(dn_sel_off ? OFF_V : LEAD_V), .done(dn_done)
  );

  pwrseq_outdec u_dec (
    .phase(phase), .had5(had5),
    .en_3v3(en_3v3), .en_5v(en_5v), .rsm_rst_n(rsm_rst_n),
    .s3_hold(s3_hold), .io_ext_en(io_ext_en), .state_code(state_code)
  );
endmodule

// File: rtl/pwrseq_chk.sv
`timescale 1ns/1ps
module pwrseq_chk #(
  parameter int unsigned T_OFF_CYC = 3_000_000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       shutdown_req,
  input logic       slp_s3_n,
  input logic       pg_3v3,
  input logic       en_3v3,
  input logic       en_5v,
  input logic       rsm_rst_n,
  input logic       s3_hold,
  input logic       io_ext_en,
  input logic [1:0] state_code
);
  logic [31:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n)                          gap <= '0;
    else if (en_3v3)                     gap <= '0;
    else if (en_5v && gap != 32'hFFFF_FFFF) gap <= gap + 1'b1;
  end

  p_5v_after_3v3_good_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_5v) |-> en_3v3 && $past(pg_3v3));

  p_hold_in_ramp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    s3_hold |-> en_3v3 && !en_5v && !rsm_rst_n);

  p_code_rails_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code != 2'd0) |-> en_3v3 && en_5v && rsm_rst_n);

  p_io_needs_s3_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    io_ext_en |-> $past(slp_s3_n) && rsm_rst_n);

  p_reset_leads_rail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_3v3) |-> !rsm_rst_n && $past(!rsm_rst_n) && $past(!rsm_rst_n, 2));

  p_off_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_5v) |-> !en_3v3 && (gap > T_OFF_CYC));

  p_shutdown_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_3v3 && !en_5v && shutdown_req) |=> !en_3v3);
endmodule

bind pwrseq_top pwrseq_chk #(.T_OFF_CYC(T_OFF_CYC)) u_chk (.*);

// File: tb/tb_pwrseq_top.sv
`timescale 1ns/1ps
module tb_pwrseq_top;
  localparam int TS = 40;
  localparam int TO = 30;
  localparam int TL = 5;

  logic clk = 1'b0;
  logic rst_n, pwr_on_req, shutdown_req, slp_sus_n, slp_s3_n, pg_3v3, pg_5v;
  logic en_3v3, en_5v, rsm_rst_n, s3_hold, io_ext_en;
  logic [1:0] state_code;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pwrseq_top #(.T_SUS_CYC(TS), .T_OFF_CYC(TO), .T_LEAD_CYC(TL)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_on_req(pwr_on_req), .shutdown_req(shutdown_req),
    .slp_sus_n(slp_sus_n), .slp_s3_n(slp_s3_n), .pg_3v3(pg_3v3), .pg_5v(pg_5v),
    .en_3v3(en_3v3), .en_5v(en_5v), .rsm_rst_n(rsm_rst_n), .s3_hold(s3_hold),
    .io_ext_en(io_ext_en), .state_code(state_code)
  );

  // Expected next code in the on region (R6).
  function automatic int next_code(input int cur, input bit s3_high);
    if (s3_high) return 3;
    return (cur == 3) ? 2 : cur;
  endfunction

  function automatic int io_for(input int code);
    return (code == 3) ? 1 : 0;
  endfunction

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic count_while_3v3(output int n);
    n = 0;
    while (en_3v3 && n < 500) begin n++; tick(); end
  endtask

  task automatic count_while_5v(output int n);
    n = 0;
    while (en_5v && n < 500) begin n++; tick(); end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R1 watchdog: actual %0d cycles expected fewer", 100000);
      summary();
      $finish;
    end
  end

  initial begin
    int n, exp_code;
    void'($urandom(32'd2024));
    rst_n = 0; pwr_on_req = 0; shutdown_req = 0; slp_sus_n = 0; slp_s3_n = 0;
    pg_3v3 = 0; pg_5v = 0;
    repeat (3) tick();
    rst_n = 1;
    tick();
    check("R1", "reset en_3v3", en_3v3, 0);
    check("R1", "reset en_5v", en_5v, 0);
    check("R1", "reset rsm_rst_n", rsm_rst_n, 0);
    check("R1", "reset s3_hold", s3_hold, 0);
    check("R1", "reset io_ext_en", io_ext_en, 0);
    check("R1", "reset code", state_code, 0);

    // Bring-up with a slow 3.3 V rail
    pwr_on_req = 1; tick(); pwr_on_req = 0;
    check("R2", "3v3 first", en_3v3, 1);
    check("R2", "5v still off", en_5v, 0);
    check("R3", "hold during ramp", s3_hold, 1);
    repeat (3) tick();
    check("R3", "hold while pg low", s3_hold, 1);
    check("R2", "5v waits pg_3v3", en_5v, 0);
    pg_3v3 = 1; tick();
    check("R2", "5v after pg_3v3", en_5v, 1);
    check("R3", "hold released", s3_hold, 0);
    check("R2", "reset held", rsm_rst_n, 0);
    pg_5v = 1; tick();
    check("R2", "reset released", rsm_rst_n, 1);
    check("R1", "code during wait", state_code, 0);
    slp_sus_n = 1; tick();
    check("R4", "soft-off code", state_code, 1);

    // Random sleep-S3 traffic in the on region
    exp_code = 1;
    for (int i = 0; i < 300; i++) begin
      bit s3;
      s3 = 1'($urandom % 2);
      slp_s3_n = s3;
      pwr_on_req = 1'($urandom % 2);
      tick();
      exp_code = next_code(exp_code, s3);
      check("R6", "code tracks sleep-S3", state_code, exp_code);
      check("R7", "io rail follows S0", io_ext_en, io_for(exp_code));
    end

    // Shutdown walk, both requests held throughout
    pwr_on_req = 1; shutdown_req = 1; tick();
    check("R8", "reset drops first", rsm_rst_n, 0);
    check("R8", "3v3 still on", en_3v3, 1);
    check("R8", "5v still on", en_5v, 1);
    count_while_3v3(n);
    check("R8", "reset lead cycles", n, TL + 1);
    check("R9", "5v on after 3v3 off", en_5v, 1);
    count_while_5v(n);
    check("R9", "off gap cycles", n, TO + 1);
    check("R1", "code after walk", state_code, 0);
    repeat (3) tick();
    check("R10", "shutdown blocks power-on", en_3v3, 0);
    pwr_on_req = 0; shutdown_req = 0; slp_s3_n = 0; slp_sus_n = 0;
    tick();

    // Attempt timeout: sleep-suspend never rises
    pwr_on_req = 1; tick(); pwr_on_req = 0;
    check("R2", "3v3 on for retry", en_3v3, 1);
    tick(); tick();
    n = 0;
    while (rsm_rst_n && n < 500) begin n++; tick(); end
    check("R5", "wait cycles before abandon", n, TS - 1);
    check("R5", "3v3 kept at abandon", en_3v3, 1);
    check("R5", "5v kept at abandon", en_5v, 1);
    count_while_3v3(n);
    check("R5", "lead on abandon", n, TL + 1);
    count_while_5v(n);
    check("R5", "gap on abandon", n, TO + 1);
    check("R5", "back to off", state_code, 0);
    tick();

    // Last-cycle success of the attempt window
    pwr_on_req = 1; tick(); pwr_on_req = 0;
    tick(); tick();
    repeat (TS - 3) tick();
    check("R5", "still waiting at edge", rsm_rst_n, 1);
    slp_sus_n = 1; tick();
    check("R5", "soft-off at last cycle", state_code, 1);
    shutdown_req = 1; tick();
    count_while_3v3(n);
    count_while_5v(n);
    shutdown_req = 0; slp_sus_n = 0;
    tick();

    // Shutdown during 3.3 V ramp: 5 V never enabled
    pg_3v3 = 0; pg_5v = 0;
    pwr_on_req = 1; tick(); pwr_on_req = 0;
    check("R3", "hold in second ramp", s3_hold, 1);
    shutdown_req = 1; tick();
    check("R10", "walk starts from ramp", s3_hold, 0);
    check("R10", "3v3 held in walk", en_3v3, 1);
    check("R9", "5v stays off in walk", en_5v, 0);
    count_while_3v3(n);
    check("R8", "lead from ramp", n, TL + 1);
    check("R9", "5v never enabled", en_5v, 0);
    repeat (TO + 2) tick();
    check("R9", "5v still off", en_5v, 0);
    shutdown_req = 0;
    tick();

    // Loss of sleep-suspend in S0
    pg_3v3 = 1; pg_5v = 1;
    pwr_on_req = 1; tick(); pwr_on_req = 0;
    tick(); tick();
    slp_sus_n = 1; tick();
    slp_s3_n = 1; tick();
    check("R7", "io on in S0", io_ext_en, 1);
    check("R6", "S0 code", state_code, 3);
    slp_sus_n = 0; tick();
    check("R11", "reset drops on suspend loss", rsm_rst_n, 0);
    check("R11", "code off on suspend loss", state_code, 0);
    check("R11", "io off on suspend loss", io_ext_en, 0);
    check("R11", "3v3 held on suspend loss", en_3v3, 1);
    count_while_3v3(n);
    count_while_5v(n);
    check("R11", "walk ends off", state_code, 0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule